// File: doc/BRIEF.md
# Cache Tag Window Unit

This unit lets software inspect and rewrite the tag store of a four-way set-associative cache through ordinary load and store cycles on a simple request/ready bus. A fixed address window is decoded. Within it, address fields pick one set entry and one way. A load returns that entry's tag, replacement bits, dirty flag and valid flag. A store replaces all four fields directly, with no associative lookup.

If a store targets a line that is both valid and dirty, the unit first asks an external memory agent to write the victim line back. The request carries the old tag, the set index and the way. The store does not complete, and the tag store is not changed, until that agent acknowledges. Accesses that are malformed complete at once with an error flag and have no side effect.

Top module: `cache_tag_window`

## Requirements
- R1: Only requests with address bits 31:24 equal to 0xF0 are answered. Any other address, including the 0xF1 data-array window, never raises `bus_ready` or `bus_err`.
- R2: An instruction fetch (`bus_ifetch`=1), or an access with `bus_size` other than 2'b10 (00 byte, 01 halfword, 10 longword), completes with `bus_err`=1 together with `bus_ready`. The tag store is left unchanged.
- R3: Address bits 13:12 select the way (0 to 3) and bits 11:4 select the entry. Each way/entry pair is stored independently.
- R4: A load returns tag in bits 31:10, replacement bits in 9:4, zero in 3:2, dirty in bit 1 and valid in bit 0. Address bit 3 (the associative bit) has no effect on loads.
- R5: A store with address bit 3 = 0 writes the tag, replacement, dirty and valid fields from the same data bit positions. Data bits 31:29 are stored as zero.
- R6: When the stored valid bit is 0, the stored dirty bit is 0, whatever the data word holds.
- R7: A store to a line holding dirty=1 and valid=1 raises `wb_req` with the old tag, index and way. These stay steady until `wb_ack`. `bus_ready` stays low while `wb_req` is high. The new fields are stored only after the acknowledge.
- R8: A store with address bit 3 = 1 completes with `bus_err`=1 and leaves the entry unchanged.
- R9: After reset every entry reads as zero, and `bus_ready`, `bus_err` and `wb_req` are low.
- R10: A load, a store to a line that is not dirty and valid, and an erroneous access each raise `bus_ready` for exactly one cycle. This happens in the cycle after the clock edge that accepted the request. `bus_err` is only ever high together with `bus_ready`.
- R11: A store to a line that is valid but clean completes without raising `wb_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_ifetch | input | 1 | Access is an instruction fetch |
| bus_size | input | 2 | Access size: 00 byte, 01 halfword, 10 longword |
| bus_addr | input | 32 | Access address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid with `bus_ready` |
| bus_ready | output | 1 | Access complete (one-cycle pulse) |
| bus_err | output | 1 | Access rejected |
| wb_req | output | 1 | Victim writeback request |
| wb_way | output | 2 | Way of the victim line |
| wb_idx | output | 8 | Entry index of the victim line |
| wb_tag | output | 22 | Old tag of the victim line |
| wb_ack | input | 1 | Writeback done |

## Verification
The embedded assertions watch the bus and writeback handshakes on every cycle. They check that `bus_ready` is a single-cycle pulse and that it never appears while a writeback is pending. They also check that the writeback fields hold steady until acknowledged, that an error never shows without ready, and that every completion follows a window request. The stored contents are visible only through loads, so field packing, tag clearing, the forced dirty clear and the way/index separation are shown by the bench's store-then-load scenarios. The same holds for the lack of side effects of rejected accesses and for the decision whether a store needs a writeback.

// File: rtl/cache_tag_window.sv
module cache_tag_window #(
  parameter int IDX_W = 8,
  parameter int WAY_W = 2,
  parameter int TAG_W = 22,
  parameter int LRU_W = 6,
  parameter logic [7:0] WIN_SEL = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic             bus_ifetch,
  input  logic [1:0]       bus_size,
  input  logic [31:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_ready,
  output logic             bus_err,
  output logic             wb_req,
  output logic [WAY_W-1:0] wb_way,
  output logic [IDX_W-1:0] wb_idx,
  output logic [TAG_W-1:0] wb_tag,
  input  logic             wb_ack
);
  localparam int SETS    = 1 << IDX_W;
  localparam int WAYS    = 1 << WAY_W;
  localparam int ENT_W   = TAG_W + LRU_W + 2;
  localparam int A_BIT   = 3;
  localparam int IDX_LSB = 4;
  localparam int WAY_LSB = IDX_LSB + IDX_W;
  localparam int LRU_LSB = 4;
  localparam int TAG_LSB = 32 - TAG_W;
  localparam int TAG_CLR = 3;
  localparam logic [1:0] SZ_LONG = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_DONE} st_t;

  st_t              st;
  logic [ENT_W-1:0] mem [WAYS][SETS];
  logic [WAY_W-1:0] p_way;
  logic [IDX_W-1:0] p_idx;
  logic [ENT_W-1:0] p_ent;
  logic [TAG_W-1:0] p_tag;
  logic [31:0]      rd_q;
  logic             err_q;

  logic             in_win, bad;
  logic [WAY_W-1:0] a_way;
  logic [IDX_W-1:0] a_idx;
  logic [ENT_W-1:0] cur, nxt;
  logic [31:0]      rd_word;
  logic             cur_u, cur_v, new_u, new_v;
  logic [TAG_W-1:0] new_tag;

  assign in_win = bus_req && (bus_addr[31:24] == WIN_SEL) && (st == S_IDLE);
  assign bad    = bus_ifetch || (bus_size != SZ_LONG) || (bus_we && bus_addr[A_BIT]);
  assign a_way  = bus_addr[WAY_LSB +: WAY_W];
  assign a_idx  = bus_addr[IDX_LSB +: IDX_W];
  assign cur    = mem[a_way][a_idx];
  assign cur_u  = cur[1];
  assign cur_v  = cur[0];

  assign new_tag = {{TAG_CLR{1'b0}}, bus_wdata[31-TAG_CLR:TAG_LSB]};
  assign new_v   = bus_wdata[0];
  assign new_u   = bus_wdata[1] & new_v;
  assign nxt     = {new_tag, bus_wdata[LRU_LSB +: LRU_W], new_u, new_v};

  always_comb begin
    rd_word = '0;
    rd_word[31:TAG_LSB] = cur[ENT_W-1 -: TAG_W];
    rd_word[LRU_LSB +: LRU_W] = cur[2 +: LRU_W];
    rd_word[1] = cur_u;
    rd_word[0] = cur_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      err_q <= 1'b0;
      rd_q  <= '0;
      p_way <= '0;
      p_idx <= '0;
      p_ent <= '0;
      p_tag <= '0;
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++)
          mem[w][s] <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_win) begin
          rd_q <= '0;
          if (bad) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else if (!bus_we) begin
            rd_q <= rd_word;
            st   <= S_DONE;
          end else if (cur_u && cur_v) begin
            p_way <= a_way;
            p_idx <= a_idx;
            p_ent <= nxt;
            p_tag <= cur[ENT_W-1 -: TAG_W];
            st    <= S_WB;
          end else begin
            mem[a_way][a_idx] <= nxt;
            st <= S_DONE;
          end
        end
        S_WB: if (wb_ack) begin
          mem[p_way][p_idx] <= p_ent;
          st <= S_DONE;
        end
        default: begin
          err_q <= 1'b0;
          st    <= S_IDLE;
        end
      endcase
    end
  end

  assign bus_ready = (st == S_DONE);
  assign bus_err   = (st == S_DONE) && err_q;
  assign bus_rdata = rd_q;
  assign wb_req    = (st == S_WB);
  assign wb_way    = p_way;
  assign wb_idx    = p_idx;
  assign wb_tag    = p_tag;

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_tag) && $stable(wb_idx) && $stable(wb_way));
  // R7
  wb_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !bus_ready);
  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);
  // R10
  err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_ready);
  // R1
  resp_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> $past(bus_req) && ($past(bus_addr[31:24]) == WIN_SEL));
  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !bus_ready && !bus_err && !wb_req);
endmodule

// File: tb/tb_cache_tag_window.sv
module tb_cache_tag_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_ifetch = 1'b0;
  logic [1:0]  bus_size = 2'b10;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, bus_err, wb_req, wb_ack = 1'b0;
  logic [1:0]  wb_way;
  logic [7:0]  wb_idx;
  logic [21:0] wb_tag;

  int checks = 0, errors = 0;
  logic [31:0] r_data;
  logic        r_err, r_ready, r_wb, r_rdy_in_wb;
  logic [21:0] r_tag;
  logic [7:0]  r_idx;
  logic [1:0]  r_way;
  int          r_lat;

  always #2.5 clk = ~clk;

  cache_tag_window dut (.*);

  function automatic logic [31:0] mk(input logic [1:0] way, input logic [7:0] idx, input logic a);
    return {8'hF0, 10'b0, way, idx, a, 3'b000};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        input logic [1:0] sz, input logic fetch, input int ack_dly, input int limit);
    int wcnt = 0;
    r_ready = 0; r_err = 0; r_wb = 0; r_rdy_in_wb = 0; r_data = '0; r_lat = 0;
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = addr; bus_wdata = wd; bus_size = sz; bus_ifetch = fetch;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      r_lat++;
      wb_ack = 0;
      if (wb_req) begin
        if (!r_wb) begin r_tag = wb_tag; r_idx = wb_idx; r_way = wb_way; end
        r_wb = 1;
        if (bus_ready) r_rdy_in_wb = 1;
        wcnt++;
        if (wcnt >= ack_dly) wb_ack = 1;
      end
      if (bus_ready) begin
        r_ready = 1; r_err = bus_err; r_data = bus_rdata;
        break;
      end
    end
    bus_req = 0; bus_we = 0; bus_ifetch = 0; bus_size = 2'b10; wb_ack = 0;
  endtask

  task automatic rd(input logic [31:0] addr);
    access(0, addr, '0, 2'b10, 0, 0, 20);
  endtask
  task automatic wr(input logic [31:0] addr, input logic [31:0] wd);
    access(1, addr, wd, 2'b10, 0, 1, 20);
  endtask

  task automatic t_reset;
    chk(!bus_ready && !bus_err && !wb_req, "R9 idle outputs", {bus_ready, bus_err, wb_req}, 0);
    rd(mk(0, 8'h00, 0));
    chk(r_ready && r_data == 0, "R9 entry w0/0 zero", r_data, 0);
    rd(mk(3, 8'hFF, 0));
    chk(r_ready && r_data == 0, "R9 entry w3/ff zero", r_data, 0);
  endtask

  task automatic t_fields;
    wr(mk(1, 8'h5A, 0), 32'h0ABC_DD51);
    rd(mk(1, 8'h5A, 0));
    chk(r_data == 32'h0ABC_DD51 && !r_err, "R5 fields stored", r_data, 32'h0ABC_DD51);
    wr(mk(0, 8'h01, 0), 32'hFFFF_FC3E);
    rd(mk(0, 8'h01, 0));
    chk(r_data == 32'h1FFF_FC30, "R4 bits 3:2 zero, U forced", r_data, 32'h1FFF_FC30);
    wr(mk(2, 8'h33, 0), 32'hFFFF_FFFF);
    rd(mk(2, 8'h33, 0));
    chk(r_data == 32'h1FFF_FFF3, "R5 tag top bits cleared", r_data, 32'h1FFF_FFF3);
  endtask

  task automatic t_ways;
    for (int w = 0; w < 4; w++) wr(mk(w[1:0], 8'hC7, 0), 32'h0000_4401 + (w << 12));
    for (int w = 0; w < 4; w++) begin
      rd(mk(w[1:0], 8'hC7, 0));
      chk(r_data == 32'h0000_4401 + (w << 12), "R3 way separation", r_data, 32'h0000_4401 + (w << 12));
    end
    rd(mk(1, 8'hC6, 0));
    chk(r_data == 0, "R3 neighbour index untouched", r_data, 0);
  endtask

  task automatic t_vclear;
    wr(mk(3, 8'h10, 0), 32'h0000_8002);
    rd(mk(3, 8'h10, 0));
    chk(r_data == 32'h0000_8000, "R6 V=0 clears U", r_data, 32'h0000_8000);
  endtask

  task automatic t_assoc;
    rd(mk(1, 8'h5A, 1));
    chk(r_data == 32'h0ABC_DD51 && !r_err, "R4 A ignored on load", r_data, 32'h0ABC_DD51);
    access(1, mk(1, 8'h5A, 1), 32'h0000_0403, 2'b10, 0, 1, 20);
    chk(r_ready && r_err, "R8 A=1 store error", r_err, 1);
    rd(mk(1, 8'h5A, 0));
    chk(r_data == 32'h0ABC_DD51, "R8 entry unchanged", r_data, 32'h0ABC_DD51);
  endtask

  task automatic t_size;
    access(0, mk(1, 8'h5A, 0), '0, 2'b00, 0, 1, 20);
    chk(r_ready && r_err, "R2 byte load error", r_err, 1);
    access(0, mk(1, 8'h5A, 0), '0, 2'b10, 1, 1, 20);
    chk(r_ready && r_err, "R2 ifetch error", r_err, 1);
    access(1, mk(1, 8'h5A, 0), 32'h0000_0403, 2'b01, 0, 1, 20);
    chk(r_ready && r_err, "R2 halfword store error", r_err, 1);
    rd(mk(1, 8'h5A, 0));
    chk(r_data == 32'h0ABC_DD51 && !r_err, "R2 entry unchanged", r_data, 32'h0ABC_DD51);
  endtask

  task automatic t_wb;
    access(1, mk(2, 8'h33, 0), 32'h0001_2C11, 2'b10, 0, 4, 40);
    chk(r_wb, "R7 writeback requested", r_wb, 1);
    chk(r_tag == 22'h07FFFF, "R7 old tag", r_tag, 22'h07FFFF);
    chk(r_idx == 8'h33 && r_way == 2, "R7 index/way", {r_way, r_idx}, {2'd2, 8'h33});
    chk(!r_rdy_in_wb && r_ready && !r_err, "R7 ready after ack", r_rdy_in_wb, 0);
    chk(r_lat == 5, "R7 completion after ack", r_lat, 5);
    rd(mk(2, 8'h33, 0));
    chk(r_data == 32'h0001_2C11, "R7 new fields stored", r_data, 32'h0001_2C11);
  endtask

  task automatic t_clean;
    wr(mk(1, 8'h5A, 0), 32'h0000_0C01);
    chk(!r_wb && r_ready, "R11 clean store no writeback", r_wb, 0);
    rd(mk(1, 8'h5A, 0));
    chk(r_lat == 1, "R10 load latency", r_lat, 1);
    access(0, mk(0, 0, 0), '0, 2'b00, 0, 1, 20);
    chk(r_lat == 1, "R10 error latency", r_lat, 1);
    @(negedge clk);
    chk(!bus_ready, "R10 ready one cycle", bus_ready, 0);
  endtask

  task automatic t_outside;
    access(0, 32'hF100_0040, '0, 2'b10, 0, 1, 6);
    chk(!r_ready && !bus_err, "R1 data window ignored", r_ready, 0);
    access(1, 32'h0000_5A50, 32'h0000_0003, 2'b10, 0, 1, 6);
    chk(!r_ready, "R1 other address ignored", r_ready, 0);
    rd(mk(1, 8'hA5, 0));
    chk(r_data == 0, "R1 no store from outside", r_data, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fields;
    t_ways;
    t_vclear;
    t_assoc;
    t_size;
    t_wb;
    t_clean;
    t_outside;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule